// File: doc/BRIEF.md
# Pipelined RGB to YCbCr Colour Converter

This block turns a stream of 24-bit RGB pixels into full-resolution (4:4:4) YCbCr pixels, one pixel per clock, with no back-pressure. Each of the three output components is produced by its own fixed-point lane that applies one colour equation. Every lane multiplies by coefficients scaled by 2^10, adds the products at full width together with the chroma offset and half an LSB for rounding, and then shifts the sum right by ten bits and saturates it to the 0..255 range.

The arithmetic takes exactly three clock cycles. The pixel-valid, line-sync and frame-sync flags go through a three-stage delay line, so they leave the block in the same cycle as the data they came in with. Downstream logic can therefore treat the output side as an ordinary video stream. Only the flag delay line is reset. The data path runs freely and carries no reset.

Top module: `rgb2ycc_conv`

## Requirements
- R1: Input red is taken from `rgb_i[23:16]`, green from `rgb_i[15:8]` and blue from `rgb_i[7:0]`. Luma, output in `ycc_o[23:16]`, is within 1 LSB of 0.299·R + 0.587·G + 0.114·B rounded to the nearest integer.
- R2: Blue-difference chroma, output in `ycc_o[15:8]`, is within 1 LSB of 0.511·B − 0.172·R − 0.339·G + 128 rounded to the nearest integer, whenever that value lies inside 0..255.
- R3: Red-difference chroma, output in `ycc_o[7:0]`, is within 1 LSB of 0.511·R − 0.428·G − 0.083·B + 128 rounded to the nearest integer, whenever that value lies inside 0..255.
- R4: A component whose real value is 256 or more is output as exactly 255. An example is chroma for pure blue or pure red input.
- R5: A component whose real value is −1 or less is output as exactly 0. An example is blue-difference chroma for yellow input.
- R6: The output word in a cycle belongs to the pixel presented three rising clock edges earlier. The path runs every cycle, whatever the value of the valid flag.
- R7: `ycc_valid_o`, `hsync_o` and `vsync_o` equal `pix_valid_i`, `hsync_i` and `vsync_i` as they were sampled three rising edges earlier.
- R8: While `rst_ni` is low, all three output flags are 0. The clear takes effect at once, without waiting for a clock edge.
- R9: For a grey input (R = G = B = v), luma is exactly v and both chroma components are exactly 128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the flag delay line |
| rgb_i | input | 24 | Input pixel: R [23:16], G [15:8], B [7:0] |
| pix_valid_i | input | 1 | Input pixel is valid |
| hsync_i | input | 1 | Input line sync |
| vsync_i | input | 1 | Input frame sync |
| ycc_o | output | 24 | Output pixel: Y [23:16], Cb [15:8], Cr [7:0] |
| ycc_valid_o | output | 1 | Output pixel is valid, delayed by three cycles |
| hsync_o | output | 1 | Line sync, delayed by three cycles |
| vsync_o | output | 1 | Frame sync, delayed by three cycles |

## Verification
The bench drives a coarse grid over the whole RGB cube, every grey level and a long run of random pixels. Each result is compared against a real-number model of the three equations.

- Saturation at both ends is aimed at with pure blue, pure red, yellow and cyan. A lane that truncated the sum instead of clamping it would wrap these values to small numbers or to numbers near 255.
- Grey inputs must give exact neutral chroma. A rounding constant added in the wrong place, or coefficients that do not cancel, would push chroma to 127 or 129.
- The flags follow a stream of irregular patterns, and an asynchronous reset is pulled in the middle of a cycle. A delay line one stage too short or too long, or a synchronous clear, would show up as misaligned or late-cleared flags.

// File: rtl/rgb2ycc_pkg.sv
`timescale 1ns/1ps
package rgb2ycc_pkg;

    localparam int NUM_CH = 3;
    localparam int PIPE_LAT = 3;

    // Equation weights in thousandths; ch 0 = luma, 1 = blue diff, 2 = red diff.
    // col 0 = red weight, 1 = green weight, 2 = blue weight.
    function automatic int weight_milli(input int ch, input int col);
        int w;
        case (ch * 3 + col)
            0: w = 299;
            1: w = 587;
            2: w = 114;
            3: w = -172;
            4: w = -339;
            5: w = 511;
            6: w = 511;
            7: w = -428;
            default: w = -83;
        endcase
        return w;
    endfunction

    // Scale a thousandths weight by 2^fw, rounding half away from zero.
    function automatic int scale_weight(input int milli, input int fw);
        int num;
        num = milli * (1 << fw);
        if (num >= 0) return (num + 500) / 1000;
        return (num - 500) / 1000;
    endfunction

endpackage

// File: rtl/rgb2ycc_lane.sv
`timescale 1ns/1ps
module rgb2ycc_lane #(
    parameter int CW   = 8,
    parameter int FW   = 10,
    parameter int K_R  = 0,
    parameter int K_G  = 0,
    parameter int K_B  = 0,
    parameter int OFS  = 0
) (
    input  logic          clk_i,
    input  logic [CW-1:0] r_i,
    input  logic [CW-1:0] g_i,
    input  logic [CW-1:0] b_i,
    output logic [CW-1:0] comp_o
);
    localparam int PW = CW + FW + 2;
    localparam int SW = PW + 3;
    localparam logic signed [PW-1:0] KR = PW'(K_R);
    localparam logic signed [PW-1:0] KG = PW'(K_G);
    localparam logic signed [PW-1:0] KB = PW'(K_B);
    localparam logic signed [SW-1:0] BIAS = SW'((OFS << FW) + (1 << (FW - 1)));
    localparam logic signed [SW-1:0] CMAX = SW'((1 << CW) - 1);

    typedef struct packed {
        logic signed [PW-1:0] p_r;
        logic signed [PW-1:0] p_g;
        logic signed [PW-1:0] p_b;
        logic signed [SW-1:0] acc;
        logic [CW-1:0]        res;
    } lane_state_t;

    lane_state_t st_d, st_q;
    logic signed [PW-1:0] r_ext, g_ext, b_ext;
    logic signed [SW-1:0] shifted;

    assign r_ext = {{(PW-CW){1'b0}}, r_i};
    assign g_ext = {{(PW-CW){1'b0}}, g_i};
    assign b_ext = {{(PW-CW){1'b0}}, b_i};

    always_comb begin
        st_d = st_q;
        // stage 1: weighted products
        st_d.p_r = r_ext * KR;
        st_d.p_g = g_ext * KG;
        st_d.p_b = b_ext * KB;
        // stage 2: full-width sum with offset and half-LSB
        st_d.acc = SW'($signed(st_q.p_r)) + SW'($signed(st_q.p_g))
                 + SW'($signed(st_q.p_b)) + BIAS;
        // stage 3: scale back and clamp
        shifted = $signed(st_q.acc) >>> FW;
        if (shifted < 0)
            st_d.res = '0;
        else if (shifted > CMAX)
            st_d.res = {CW{1'b1}};
        else
            st_d.res = shifted[CW-1:0];
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign comp_o = st_q.res;

endmodule

// File: rtl/rgb2ycc_flag_delay.sv
`timescale 1ns/1ps
module rgb2ycc_flag_delay #(
    parameter int W     = 3,
    parameter int DEPTH = 3
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] flags_i,
    output logic [W-1:0] flags_o
);
    typedef logic [W-1:0] stage_t;

    stage_t [DEPTH-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = flags_i;
        for (int i = 1; i < DEPTH; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q <= '0;
        else         pipe_q <= pipe_d;
    end

    assign flags_o = pipe_q[DEPTH-1];

    // cycles since reset, saturating at 3, used only to gate the check
    logic [1:0] age_d, age_q;
    always_comb age_d = (age_q == 2'd3) ? age_q : age_q + 2'd1;
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) age_q <= '0;
        else         age_q <= age_d;
    end

    // R7: flags leave exactly three edges after they were sampled
    assert_flag_align_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (DEPTH == 3 && age_q == 2'd3) |-> (flags_o == $past(flags_i, 3)));

endmodule

// File: rtl/rgb2ycc_conv.sv
`timescale 1ns/1ps
module rgb2ycc_conv #(
    parameter int CW = 8,
    parameter int FW = 10
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [3*CW-1:0] rgb_i,
    input  logic            pix_valid_i,
    input  logic            hsync_i,
    input  logic            vsync_i,
    output logic [3*CW-1:0] ycc_o,
    output logic            ycc_valid_o,
    output logic            hsync_o,
    output logic            vsync_o
);
    import rgb2ycc_pkg::*;

    localparam int MID = 1 << (CW - 1);

    logic [CW-1:0] r_c, g_c, b_c;
    assign r_c = rgb_i[2*CW +: CW];
    assign g_c = rgb_i[CW +: CW];
    assign b_c = rgb_i[0 +: CW];

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_lane
        rgb2ycc_lane #(
            .CW (CW),
            .FW (FW),
            .K_R(scale_weight(weight_milli(ch, 0), FW)),
            .K_G(scale_weight(weight_milli(ch, 1), FW)),
            .K_B(scale_weight(weight_milli(ch, 2), FW)),
            .OFS((ch == 0) ? 0 : MID)
        ) u_lane (
            .clk_i (clk_i),
            .r_i   (r_c),
            .g_i   (g_c),
            .b_i   (b_c),
            .comp_o(ycc_o[(NUM_CH-1-ch)*CW +: CW])
        );
    end

    logic [2:0] flags_out;
    rgb2ycc_flag_delay #(
        .W    (3),
        .DEPTH(PIPE_LAT)
    ) u_flags (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .flags_i({pix_valid_i, hsync_i, vsync_i}),
        .flags_o(flags_out)
    );
    assign {ycc_valid_o, hsync_o, vsync_o} = flags_out;

    // cycles since reset, saturating at 3, used only to gate the checks
    logic [1:0] age_d, age_q;
    always_comb age_d = (age_q == 2'd3) ? age_q : age_q + 2'd1;
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) age_q <= '0;
        else         age_q <= age_d;
    end

    localparam logic [CW-1:0] ZERO = '0;
    localparam logic [CW-1:0] FULL = '1;
    localparam logic [CW-1:0] MIDV = CW'(MID);

    // R9: grey in, neutral chroma and identical luma out
    assert_grey_neutral_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (age_q == 2'd3 && $past(r_c, 3) == $past(g_c, 3) && $past(g_c, 3) == $past(b_c, 3))
        |-> (ycc_o == {$past(r_c, 3), MIDV, MIDV}));

    // R4: pure blue drives blue-difference chroma to the top
    assert_cb_sat_high_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (age_q == 2'd3 && $past(rgb_i, 3) == {ZERO, ZERO, FULL})
        |-> (ycc_o[CW +: CW] == FULL));

    // R4: pure red drives red-difference chroma to the top
    assert_cr_sat_high_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (age_q == 2'd3 && $past(rgb_i, 3) == {FULL, ZERO, ZERO})
        |-> (ycc_o[0 +: CW] == FULL));

    // R5: yellow drives blue-difference chroma to the floor
    assert_cb_sat_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (age_q == 2'd3 && $past(rgb_i, 3) == {FULL, FULL, ZERO})
        |-> (ycc_o[CW +: CW] == ZERO));

endmodule

// File: tb/rgb2ycc_conv_bench.sv
`timescale 1ns/1ps
module rgb2ycc_conv_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] rgb = '0;
    logic        valid = 1'b0, hs = 1'b0, vs = 1'b0;
    logic [23:0] ycc;
    logic        valid_o, hs_o, vs_o;

    always #2.5 clk = ~clk;

    rgb2ycc_conv u_rgb2ycc_conv (
        .clk_i(clk), .rst_ni(rst_n), .rgb_i(rgb),
        .pix_valid_i(valid), .hsync_i(hs), .vsync_i(vs),
        .ycc_o(ycc), .ycc_valid_o(valid_o), .hsync_o(hs_o), .vsync_o(vs_o)
    );

    int errors = 0;
    int checks = 0;
    int n = 0;
    bit done = 1'b0;
    logic [23:0] h_rgb [4];
    logic [2:0]  h_flg [4];

    task automatic note(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int round_clamp(input real v);
        int k;
        if (v < 0.0) return 0;
        k = $rtoi(v + 0.5);
        return (k > 255) ? 255 : k;
    endfunction

    task automatic check_comp(input string req, input int got, input real f);
        int e;
        e = round_clamp(f);
        if (f >= 256.0)
            note(got == 255, {req, " R4 high clamp"}, got, 255);
        else if (f <= -1.0)
            note(got == 0, {req, " R5 low clamp"}, got, 0);
        else
            note((got - e) <= 1 && (e - got) <= 1, {req, " R6 aligned value"}, got, e);
    endtask

    task automatic check_out(input logic [23:0] p, input logic [2:0] fl);
        real r, g, b;
        int gy, gb, gr;
        r = real'(p[23:16]); g = real'(p[15:8]); b = real'(p[7:0]);
        gy = int'(ycc[23:16]); gb = int'(ycc[15:8]); gr = int'(ycc[7:0]);
        if (p[23:16] == p[15:8] && p[15:8] == p[7:0]) begin
            note(gy == int'(p[23:16]), "R9 grey luma", gy, int'(p[23:16]));
            note(gb == 128, "R9 grey Cb", gb, 128);
            note(gr == 128, "R9 grey Cr", gr, 128);
        end else begin
            check_comp("R1 luma", gy, 0.299*r + 0.587*g + 0.114*b);
            check_comp("R2 Cb", gb, -0.172*r - 0.339*g + 0.511*b + 128.0);
            check_comp("R3 Cr", gr, 0.511*r - 0.428*g - 0.083*b + 128.0);
        end
        note({valid_o, hs_o, vs_o} == fl, "R7 flags", int'({valid_o, hs_o, vs_o}), int'(fl));
    endtask

    task automatic step(input logic [7:0] r, input logic [7:0] g, input logic [7:0] b);
        logic [2:0] fl;
        @(negedge clk);
        if (n >= 3) check_out(h_rgb[(n-3)%4], h_flg[(n-3)%4]);
        fl = {(n % 7) != 0, (n % 50) < 3, (n % 1000) < 5};
        {valid, hs, vs} = fl;
        rgb = {r, g, b};
        h_rgb[n%4] = {r, g, b};
        h_flg[n%4] = fl;
        n++;
    endtask

    task automatic summary;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R8: flags are clear while reset is held
        note({valid_o, hs_o, vs_o} == 3'b000, "R8 flags in reset", int'({valid_o, hs_o, vs_o}), 0);
        valid = 1'b1; hs = 1'b1; vs = 1'b1;
        @(negedge clk);
        note({valid_o, hs_o, vs_o} == 3'b000, "R8 flags held clear", int'({valid_o, hs_o, vs_o}), 0);
        rst_n = 1'b1;

        // corners: pure primaries, secondaries, black and white
        step(8'h00, 8'h00, 8'hFF); step(8'hFF, 8'h00, 8'h00); step(8'hFF, 8'hFF, 8'h00);
        step(8'h00, 8'hFF, 8'hFF); step(8'h00, 8'hFF, 8'h00); step(8'hFF, 8'h00, 8'hFF);
        step(8'h00, 8'h00, 8'h00); step(8'hFF, 8'hFF, 8'hFF); step(8'h01, 8'h00, 8'hFE);
        // every grey level
        for (int v = 0; v < 256; v++) step(8'(v), 8'(v), 8'(v));
        // coarse grid over the cube
        for (int r = 0; r < 256; r += 17)
            for (int g = 0; g < 256; g += 17)
                for (int b = 0; b < 256; b += 17)
                    step(8'(r), 8'(g), 8'(b));
        // random pixels
        for (int i = 0; i < 30000; i++) begin
            logic [31:0] w;
            w = $urandom;
            step(w[23:16], w[15:8], w[7:0]);
        end
        // flush the pipeline
        repeat (3) step(8'h00, 8'h00, 8'h00);

        // R8: asynchronous clear in the middle of a cycle
        @(negedge clk);
        valid = 1'b1; hs = 1'b1; vs = 1'b1;
        repeat (4) @(negedge clk);
        note({valid_o, hs_o, vs_o} == 3'b111, "R7 flags before clear", int'({valid_o, hs_o, vs_o}), 7);
        #1 rst_n = 1'b0;
        #0.5;
        note({valid_o, hs_o, vs_o} == 3'b000, "R8 async clear", int'({valid_o, hs_o, vs_o}), 0);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", n, 0);
            summary();
            $finish;
        end
    end

endmodule